// File: doc/BRIEF.md
# Power-On Elapsed Seconds Counter

This block keeps two free-running uptime counters, each counting whole seconds. One advances while the main supply reports power good; the other advances while the standby supply reports power good. A shared prescaler turns a 32.768 kHz reference strobe into a one-second tick, so both counters step on the same tick. The counters live in the battery-backed domain and are cleared only by the battery power-on reset.

Two host ports read the counters as byte registers, each with its own address map: a runtime register port and an SMBus-style register port. The ports are read-only and need no arbitration. A read of a counter's low byte returns the live low byte and, in the same cycle, freezes the three upper bytes in a per-port, per-counter holding register. Later reads of the upper bytes return the frozen values. Software reads low byte first and high byte last, and gets a value that cannot tear, while counting goes on. Read data appears on the port's data output one cycle after the read strobe.

Top module: `uptime_elapsed_timer`

## Requirements
- R1: The prescaler produces one tick for every PRESCALE reference strobes (default 32768); after reset, the first tick comes with the PRESCALE-th strobe, and cycles with no strobe leave it unchanged.
- R2: Each 32-bit counter increases by exactly one on every tick while its power-good input is high.
- R3: A counter whose power-good input is low holds its value across ticks, and the other counter is not affected.
- R4: The battery reset clears both counters, the prescaler, all holding registers and both read-data outputs to zero.
- R5: A counter holding all ones returns to zero on its next enabled tick.
- R6: A read of a counter's byte index 0 returns, one cycle later, the low byte the counter held in the strobe cycle. That same cycle captures byte indices 1 to 3, and counting is not paused.
- R7: Reads of byte indices 1 to 3 return the bytes captured by that port's most recent index-0 read of the same counter, even if the counter has moved on.
- R8: Runtime port map: main counter byte index i is at 0x6D+i and standby counter byte index i is at 0x71+i, for i from 0 to 3.
- R9: SMBus port map: main counter byte indices 0, 1, 2, 3 are at 0x0A, 0x0B, 0x04, 0x05; standby counter byte index i is at 0x06+i.
- R10: Each port has its own holding register per counter, so an index-0 read on one port does not change what the other port returns for indices 1 to 3.
- R11: A read of an address outside the port's map, or of a byte index at or above CNT_W/8, returns 0x00.
- R12: A cycle with the write strobe high is ignored: it captures nothing, leaves the read data unchanged and does not affect counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| bat_rst_ni | input | 1 | Battery-domain power-on reset, active low, asynchronous |
| ref_pulse_i | input | 1 | One-cycle strobe per 32.768 kHz reference period |
| main_pg_i | input | 1 | Main supply power good |
| stby_pg_i | input | 1 | Standby supply power good |
| rt_rd_i | input | 1 | Runtime port read strobe |
| rt_wr_i | input | 1 | Runtime port write strobe (ignored) |
| rt_addr_i | input | 8 | Runtime port byte address |
| rt_rdata_o | output | 8 | Runtime port read data, one cycle after the strobe |
| sm_rd_i | input | 1 | SMBus port read strobe |
| sm_wr_i | input | 1 | SMBus port write strobe (ignored) |
| sm_addr_i | input | 8 | SMBus port byte address |
| sm_rdata_o | output | 8 | SMBus port read data, one cycle after the strobe |

## Verification
On every cycle, the assertions check the prescaler's step and wrap, the counters' step, hold and wrap to zero, and the read ports' rules: the low-byte read returns the live byte, holding registers change only on a low-byte read, unmapped reads return zero and write cycles change nothing. Only the bench scenarios show that the address maps put each byte where R8 and R9 say, and that a snapshot stays untorn across a low-byte carry while counting continues. They also show that the two ports keep separate snapshots and that the first tick after reset comes with the right strobe. A second, narrower instance drives a counter through its wrap in reachable time.

// File: rtl/uptime_pkg.sv
package uptime_pkg;

    localparam int NUM_CNT   = 2;   // 0: main supply, 1: standby supply
    localparam int MAX_BYTES = 4;   // byte slots per counter in each map

    typedef enum logic {
        MAP_RUNTIME = 1'b0,
        MAP_SMBUS   = 1'b1
    } map_e;

    typedef struct packed {
        logic       hit;
        logic       sel;   // counter select
        logic [1:0] idx;   // byte index, 0 = least significant
    } dec_t;

    // Address decode for both host maps.
    function automatic dec_t decode_addr(map_e m, logic [7:0] a);
        dec_t       r;
        logic [7:0] off;
        r   = '0;
        off = '0;
        if (m == MAP_RUNTIME) begin
            if (a >= 8'h6D && a <= 8'h74) begin
                off   = a - 8'h6D;
                r.hit = 1'b1;
                r.sel = off[2];
                r.idx = off[1:0];
            end
        end else begin
            case (a)
                8'h0A: r = '{hit: 1'b1, sel: 1'b0, idx: 2'd0};
                8'h0B: r = '{hit: 1'b1, sel: 1'b0, idx: 2'd1};
                8'h04: r = '{hit: 1'b1, sel: 1'b0, idx: 2'd2};
                8'h05: r = '{hit: 1'b1, sel: 1'b0, idx: 2'd3};
                8'h06, 8'h07, 8'h08, 8'h09: begin
                    off   = a - 8'h06;
                    r.hit = 1'b1;
                    r.sel = 1'b1;
                    r.idx = off[1:0];
                end
                default: r = '0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/uptime_prescaler.sv
module uptime_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_pulse_i,
    output logic sec_tick_o
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        sec_tick_o = 1'b0;
        if (ref_pulse_i) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt   = '0;
                sec_tick_o = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R1: a tick restarts the division
    p_tick_restart_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sec_tick_o |=> st_q.cnt == '0);
    // R1: no strobe, no progress
    p_idle_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ref_pulse_i |=> $stable(st_q.cnt));
    p_idle_no_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ref_pulse_i |-> !sec_tick_o);

endmodule

// File: rtl/uptime_counter.sv
module uptime_counter #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic         en_i,
    output logic [W-1:0] count_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    step;

    always_comb begin
        st_d = st_q;
        step = tick_i && en_i;
        if (step) st_d.cnt = st_q.cnt + 1'b1;   // all ones wraps to zero
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign count_o = st_q.cnt;

    p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && en_i && count_o != '1) |=> count_o == $past(count_o) + 1'b1);
    p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(count_o));
    p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && en_i && count_o == '1) |=> count_o == '0);

endmodule

// File: rtl/uptime_read_port.sv
module uptime_read_port #(
    parameter int               W   = 32,
    parameter uptime_pkg::map_e MAP = uptime_pkg::MAP_RUNTIME
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         rd_i,
    input  logic         wr_i,
    input  logic [7:0]   addr_i,
    input  logic [W-1:0] cnt_main_i,
    input  logic [W-1:0] cnt_stby_i,
    output logic [7:0]   rdata_o
);
    // W must be a multiple of 8 between 16 and 32.
    localparam int NBYTES = W / 8;
    localparam int SNAP_W = W - 8;
    localparam int WIDE_W = (uptime_pkg::MAX_BYTES - 1) * 8;

    typedef struct packed {
        logic [uptime_pkg::NUM_CNT-1:0][SNAP_W-1:0] snap;
        logic [7:0]                                 rdata;
    } port_st_t;

    port_st_t          st_d, st_q;
    uptime_pkg::dec_t  dec;
    logic [W-1:0]      live;
    logic [WIDE_W-1:0] wide;
    logic              rd_ok;
    logic              lsb_rd;

    always_comb begin
        st_d   = st_q;
        dec    = uptime_pkg::decode_addr(MAP, addr_i);
        live   = dec.sel ? cnt_stby_i : cnt_main_i;
        wide   = '0;
        rd_ok  = rd_i && !wr_i;
        lsb_rd = rd_ok && dec.hit && (dec.idx == 2'd0);
        if (rd_ok) begin
            if (!dec.hit || int'(dec.idx) >= NBYTES) begin
                st_d.rdata = '0;
            end else if (dec.idx == 2'd0) begin
                st_d.rdata         = live[7:0];
                st_d.snap[dec.sel] = live[W-1:8];
            end else begin
                wide[SNAP_W-1:0] = st_q.snap[dec.sel];
                st_d.rdata       = wide[(int'(dec.idx) - 1) * 8 +: 8];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;

    p_lsb_live_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lsb_rd |=> rdata_o == $past(live[7:0]));
    p_snap_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lsb_rd |=> $stable(st_q.snap));
    p_unmapped_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_ok && !dec.hit) |=> rdata_o == 8'h00);
    p_write_ignored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> ($stable(rdata_o) && $stable(st_q.snap)));

endmodule

// File: rtl/uptime_elapsed_timer.sv
module uptime_elapsed_timer #(
    parameter int PRESCALE = 32768,
    parameter int CNT_W    = 32
) (
    input  logic       clk_i,
    input  logic       bat_rst_ni,
    input  logic       ref_pulse_i,
    input  logic       main_pg_i,
    input  logic       stby_pg_i,
    input  logic       rt_rd_i,
    input  logic       rt_wr_i,
    input  logic [7:0] rt_addr_i,
    output logic [7:0] rt_rdata_o,
    input  logic       sm_rd_i,
    input  logic       sm_wr_i,
    input  logic [7:0] sm_addr_i,
    output logic [7:0] sm_rdata_o
);
    localparam int NC = uptime_pkg::NUM_CNT;
    localparam int NP = 2;

    logic                       sec_tick;
    logic [NC-1:0]              pg;
    logic [NC-1:0][CNT_W-1:0]   cnt;
    logic [NP-1:0]              p_rd, p_wr;
    logic [NP-1:0][7:0]         p_addr, p_rdata;

    assign pg     = {stby_pg_i, main_pg_i};
    assign p_rd   = {sm_rd_i, rt_rd_i};
    assign p_wr   = {sm_wr_i, rt_wr_i};
    assign p_addr = {sm_addr_i, rt_addr_i};
    assign rt_rdata_o = p_rdata[0];
    assign sm_rdata_o = p_rdata[1];

    uptime_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk_i       (clk_i),
        .rst_ni      (bat_rst_ni),
        .ref_pulse_i (ref_pulse_i),
        .sec_tick_o  (sec_tick)
    );

    for (genvar gc = 0; gc < NC; gc++) begin : g_cnt
        uptime_counter #(.W(CNT_W)) u_cnt (
            .clk_i   (clk_i),
            .rst_ni  (bat_rst_ni),
            .tick_i  (sec_tick),
            .en_i    (pg[gc]),
            .count_o (cnt[gc])
        );
    end

    for (genvar gp = 0; gp < NP; gp++) begin : g_port
        localparam uptime_pkg::map_e M =
            (gp == 0) ? uptime_pkg::MAP_RUNTIME : uptime_pkg::MAP_SMBUS;
        uptime_read_port #(.W(CNT_W), .MAP(M)) u_port (
            .clk_i      (clk_i),
            .rst_ni     (bat_rst_ni),
            .rd_i       (p_rd[gp]),
            .wr_i       (p_wr[gp]),
            .addr_i     (p_addr[gp]),
            .cnt_main_i (cnt[0]),
            .cnt_stby_i (cnt[1]),
            .rdata_o    (p_rdata[gp])
        );
    end

endmodule

// File: tb/tb_uptime_elapsed_timer.sv
module tb_uptime_elapsed_timer;

    localparam int P  = 4;    // prescale for the main instance
    localparam int PW = 2;    // prescale for the wrap instance (16-bit)

    logic clk = 1'b0;
    always #2 clk = ~clk;     // 250 MHz

    logic       rst_n = 1'b0;
    logic       ref_pulse = 1'b0, manual_ref = 1'b0;
    int         ref_ctl = 0;  // 0 manual, 1 random, 2 always on
    logic       main_pg = 1'b0, stby_pg = 1'b0;
    logic       rt_rd = 1'b0, rt_wr = 1'b0, sm_rd = 1'b0, sm_wr = 1'b0;
    logic [7:0] rt_addr = '0, sm_addr = '0;
    logic [7:0] rt_rdata, sm_rdata;

    logic       w_rd = 1'b0;
    logic [7:0] w_addr = '0;
    logic [7:0] w_rdata, w_sm_rdata;

    int n_chk = 0, n_bad = 0;

    uptime_elapsed_timer #(.PRESCALE(P), .CNT_W(32)) dut (
        .clk_i(clk), .bat_rst_ni(rst_n), .ref_pulse_i(ref_pulse),
        .main_pg_i(main_pg), .stby_pg_i(stby_pg),
        .rt_rd_i(rt_rd), .rt_wr_i(rt_wr), .rt_addr_i(rt_addr), .rt_rdata_o(rt_rdata),
        .sm_rd_i(sm_rd), .sm_wr_i(sm_wr), .sm_addr_i(sm_addr), .sm_rdata_o(sm_rdata)
    );

    uptime_elapsed_timer #(.PRESCALE(PW), .CNT_W(16)) dut_w (
        .clk_i(clk), .bat_rst_ni(rst_n), .ref_pulse_i(1'b1),
        .main_pg_i(1'b1), .stby_pg_i(1'b1),
        .rt_rd_i(w_rd), .rt_wr_i(1'b0), .rt_addr_i(w_addr), .rt_rdata_o(w_rdata),
        .sm_rd_i(1'b0), .sm_wr_i(1'b0), .sm_addr_i(8'h00), .sm_rdata_o(w_sm_rdata)
    );

    // Reference models built from R1 to R5
    int          m_pre, mw_pre;
    logic [31:0] m_cnt [2];
    logic [15:0] mw_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre <= 0; m_cnt[0] <= '0; m_cnt[1] <= '0;
        end else if (ref_pulse) begin
            if (m_pre == P - 1) begin
                m_pre <= 0;
                if (main_pg) m_cnt[0] <= m_cnt[0] + 1;
                if (stby_pg) m_cnt[1] <= m_cnt[1] + 1;
            end else m_pre <= m_pre + 1;
        end
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mw_pre <= 0; mw_cnt <= '0;
        end else if (mw_pre == PW - 1) begin
            mw_pre <= 0; mw_cnt <= mw_cnt + 1;
        end else mw_pre <= mw_pre + 1;
    end

    always @(negedge clk)
        ref_pulse <= (ref_ctl == 1) ? (($urandom % 4) != 0) :
                     (ref_ctl == 2) ? 1'b1 : manual_ref;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R8 / R9 address maps
    function automatic logic [7:0] addr_of(input int port, input int sel, input int idx);
        if (port == 1) begin
            if (sel == 1) return 8'(8'h06 + idx);
            return (idx < 2) ? 8'(8'h0A + idx) : 8'(8'h04 + idx - 2);
        end
        return 8'(8'h6D + sel * 4 + idx);
    endfunction

    function automatic bit mapped(input int port, input logic [7:0] a);
        if (port == 1) return (a >= 8'h04 && a <= 8'h0B);
        return (a >= 8'h6D && a <= 8'h74);
    endfunction

    // Called at a negedge; port 0 runtime, 1 SMBus, 2 wrap instance.
    task automatic port_op(input int port, input logic [7:0] a, input bit wr,
                           output logic [7:0] d, output logic [31:0] m0,
                           output logic [31:0] m1);
        m0 = (port == 2) ? 32'(mw_cnt) : m_cnt[0];
        m1 = (port == 2) ? 32'(mw_cnt) : m_cnt[1];
        case (port)
            0: begin rt_rd = 1'b1; rt_wr = wr; rt_addr = a; end
            1: begin sm_rd = 1'b1; sm_wr = wr; sm_addr = a; end
            default: begin w_rd = 1'b1; w_addr = a; end
        endcase
        @(negedge clk);
        d = (port == 0) ? rt_rdata : (port == 1) ? sm_rdata : w_rdata;
        rt_rd = 1'b0; rt_wr = 1'b0; sm_rd = 1'b0; sm_wr = 1'b0; w_rd = 1'b0;
    endtask

    task automatic read_lsb(input int port, input int sel, input string tag,
                            output logic [31:0] snap);
        logic [7:0]  d;
        logic [31:0] m0, m1;
        port_op(port, addr_of(port, sel, 0), 1'b0, d, m0, m1);
        snap = sel ? m1 : m0;
        check(tag, 32'(d), 32'(snap[7:0]));
    endtask

    task automatic read_upper(input int port, input int sel, input int gap,
                              input logic [31:0] snap, input string tag);
        logic [7:0]  d;
        logic [31:0] m0, m1;
        for (int i = 1; i < 4; i++) begin
            repeat (gap) @(negedge clk);
            port_op(port, addr_of(port, sel, i), 1'b0, d, m0, m1);
            check(tag, 32'(d), 32'(snap[8*i +: 8]));
        end
    endtask

    task automatic run_all();
        logic [31:0] s, s2, m0, m1;
        logic [7:0]  d, keep;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R4: reset state
        check("R4 rt_rdata after reset", 32'(rt_rdata), 0);
        check("R4 sm_rdata after reset", 32'(sm_rdata), 0);
        main_pg = 1'b1; stby_pg = 1'b1;
        read_lsb(0, 0, "R4 main count after reset", s);
        check("R4 main zero", s, 0);
        read_lsb(1, 1, "R4 stby count after reset", s);
        check("R4 stby zero", s, 0);

        // R1: first tick on the P-th strobe, gaps do not count
        for (int i = 0; i < P - 1; i++) begin
            manual_ref = 1'b1; @(negedge clk); manual_ref = 1'b0;
            repeat (3) @(negedge clk);
        end
        port_op(0, 8'h6D, 1'b0, d, m0, m1);
        check("R1 no tick before P strobes", 32'(d), 0);
        manual_ref = 1'b1; @(negedge clk); manual_ref = 1'b0; @(negedge clk);
        port_op(0, 8'h6D, 1'b0, d, m0, m1);
        check("R1 R2 one tick after P strobes", 32'(d), 1);
        port_op(1, 8'h06, 1'b0, d, m0, m1);
        check("R2 stby one tick", 32'(d), 1);

        // R3: main disabled, standby continues
        main_pg = 1'b0; ref_ctl = 2;
        repeat (400) @(negedge clk);
        ref_ctl = 0; @(negedge clk);
        read_lsb(0, 0, "R3 main held", s);
        check("R3 main held value", s, 1);
        read_upper(0, 0, 0, s, "R3 main upper bytes");
        read_lsb(1, 1, "R3 R2 stby advanced", s);
        check("R3 stby value", s, 101);
        main_pg = 1'b1;

        // R7: snapshot survives a carry out of the low byte
        ref_ctl = 2;
        while (m_cnt[0][7:0] != 8'hFE) @(negedge clk);
        read_lsb(0, 0, "R6 live lsb near carry", s);
        repeat (40) @(negedge clk);
        read_upper(0, 0, 0, s, "R7 untorn upper bytes");
        check("R6 counting continued", 32'(m_cnt[0] > s), 1);

        // R10: separate snapshots per port
        read_lsb(0, 0, "R10 rt lsb", s);
        repeat (1300) @(negedge clk);
        read_lsb(1, 0, "R10 sm lsb", s2);
        read_upper(0, 0, 2, s, "R10 rt keeps own snapshot");
        read_upper(1, 0, 1, s2, "R10 sm keeps own snapshot");

        // R12: writes are ignored
        read_lsb(0, 1, "R12 setup lsb", s);
        keep = rt_rdata;
        repeat (30) @(negedge clk);
        port_op(0, 8'h71, 1'b1, d, m0, m1);
        check("R12 rdata unchanged by write", 32'(d), 32'(keep));
        port_op(0, 8'h72, 1'b1, d, m0, m1);
        check("R12 rdata unchanged by write 2", 32'(d), 32'(keep));
        read_upper(0, 1, 0, s, "R12 snapshot unchanged by write");
        ref_ctl = 0; @(negedge clk);
        read_lsb(0, 1, "R12 count unaffected", s2);
        check("R12 count matches model", s2, m_cnt[1]);

        // Random mix: R8, R9, R11
        ref_ctl = 1;
        for (int it = 0; it < 60; it++) begin
            int port, sel, gap;
            logic [7:0] a;
            port = $urandom % 2; sel = $urandom % 2; gap = $urandom % 25;
            main_pg = ($urandom % 4) != 0; stby_pg = ($urandom % 4) != 0;
            if (($urandom % 4) == 0) begin
                a = 8'($urandom);
                while (mapped(port, a)) a = 8'($urandom);
                port_op(port, a, 1'b0, d, m0, m1);
                check("R11 unmapped reads zero", 32'(d), 0);
            end else begin
                read_lsb(port, sel, port ? "R9 sm lsb" : "R8 rt lsb", s);
                read_upper(port, sel, gap, s, port ? "R9 sm upper" : "R8 rt upper");
            end
        end
        ref_ctl = 0;

        // R5: wrap on the 16-bit instance; byte 2 is past CNT_W/8
        while (mw_cnt != 16'hFFFF) @(negedge clk);
        read_lsb(2, 0, "R5 lsb at all ones", s);
        check("R5 model at all ones", s, 32'hFFFF);
        port_op(2, 8'h6E, 1'b0, d, m0, m1);
        check("R5 high byte before wrap", 32'(d), 32'hFF);
        while (mw_cnt != 16'h0002) @(negedge clk);
        read_lsb(2, 0, "R5 lsb after wrap", s);
        check("R5 wrapped low", s, 2);
        port_op(2, 8'h6E, 1'b0, d, m0, m1);
        check("R5 high byte after wrap", 32'(d), 0);
        port_op(2, 8'h6F, 1'b0, d, m0, m1);
        check("R11 index beyond width reads zero", 32'(d), 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule